// File: doc/BRIEF.md
# Reset-Latched External Bus Configuration

This block decides, at power-up, how a chip talks to its external memory bus. While system reset is held it watches a handful of strap pins. When reset is released it keeps what it last saw in a small set of configuration registers. The captured settings are the bus type (data width and address mode), the write-strobe style and the number of chip-select lines in use. An internal-start flag overrides the bus type straps and forces the narrowest demultiplexed setting.

After reset, software may rewrite the bus type, the byte-disable bit and the write-configuration bit through a single write port. The chip-select count is locked from the end of reset onward. The block then steers two 16-bit ports from the live bus type. In multiplexed mode the low port carries the address and then the write data, and the second port stays undriven. In demultiplexed mode the second port carries the address and the low port carries only data. The block also gates byte-high-enable and hands unused chip-select pins back to general-purpose use.

Top module: `bus_strap_cfg`

## Requirements
- R1: While `rst` is high the registers load from the straps on every rising clock edge, so the values held after reset are those sampled at the last edge with `rst` high. The bus type reads back on `cfg_rd[1:0]` as {`strap_bus[1]`, `strap_bus[0]`}. Bit 1 gives the width (1 = 16-bit, 0 = 8-bit) and bit 0 gives the address mode (1 = multiplexed, 0 = demultiplexed).
- R2: If `int_start` is high at a reset sample, the bus type is loaded as 2'b00 whatever `strap_bus` holds.
- R3: The write-config bit `cfg_rd[3]` is loaded with the inverse of `strap_wr`. `wr_split` equals that bit, where 1 means separate high and low write strobes.
- R4: The chip-select count `cfg_rd[5:4]` is loaded from `strap_cs` only during reset, and software writes leave it unchanged. `cs_en` is 4'b1111 for code 00, 4'b0000 for 01, 4'b0011 for 10 and 4'b0111 for 11. A 0 bit hands that pin to GPIO.
- R5: When `sw_we` is high out of reset, `sw_wdata[1:0]` is written to the bus type, `sw_wdata[2]` to byte-disable and `sw_wdata[3]` to write-config on that edge. `sw_wdata[5:4]` is ignored. Port steering follows the new bus type in the next cycle.
- R6: In multiplexed mode `p1_oe` is all zero. `p0_out` is `bus_addr` when `bus_phase` is 0 and `bus_wdata` when it is 1. With `bus_drv` high, `p0_oe` is 16'hFFFF in the address phase. In the data phase it is 16'hFFFF on a 16-bit bus and 16'h00FF on an 8-bit bus. With `bus_drv` low every enable is 0.
- R7: In demultiplexed mode `p1_out` is `bus_addr` and `p0_out` is `bus_wdata`. `p1_oe` is 16'hFFFF whenever `bus_drv` is high. `p0_oe` is non-zero only when `bus_drv` and `bus_phase` are both high: 16'hFFFF on a 16-bit bus and 16'h00FF on an 8-bit bus.
- R8: The byte-disable bit `cfg_rd[2]` is loaded during reset as the inverse of the captured width bit. `bhe_en` is high only when both byte-disable and write-config are 0.
- R9: Out of reset, with `sw_we` low, every configuration field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, active high; straps are sampled while high |
| strap_bus | input | 2 | Bus type straps {width, mux} |
| strap_wr | input | 1 | Write-style strap, 1 = single strobe plus byte-high-enable |
| strap_cs | input | 2 | Chip-select count strap |
| int_start | input | 1 | Internal start; overrides the bus type straps |
| sw_we | input | 1 | Software configuration write strobe |
| sw_wdata | input | 6 | Software write data, same layout as `cfg_rd` |
| bus_drv | input | 1 | Bus controller is driving a write cycle |
| bus_phase | input | 1 | 0 = address phase, 1 = data phase |
| bus_addr | input | 16 | Intra-segment address |
| bus_wdata | input | 16 | Write data |
| cfg_rd | output | 6 | Read-back {cs count, write-config, byte-disable, bus type} |
| p0_out | output | 16 | Low port output value |
| p0_oe | output | 16 | Low port per-bit output enable |
| p1_out | output | 16 | Second port output value |
| p1_oe | output | 16 | Second port per-bit output enable |
| bhe_en | output | 1 | Byte-high-enable pin active |
| wr_split | output | 1 | Separate high/low write strobes selected |
| cs_en | output | 4 | Per-line chip-select enable, 0 = GPIO |

## Verification
The hardest situation to create is the freeze at the reset edge. The value kept must come from the last sampled cycle and not an earlier one, and an internal start must win over straps that point elsewhere. The stimulus changes the straps and `int_start` on each cycle of a multi-cycle reset, so only the final sample can match the model. It also mixes software writes that set the locked chip-select bits with bus traffic in both phases, so steering is checked right after each bus type change.

// File: rtl/bus_strap_cfg.sv
module bus_strap_cfg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    strap_bus,
  input  logic          strap_wr,
  input  logic [1:0]    strap_cs,
  input  logic          int_start,
  input  logic          sw_we,
  input  logic [5:0]    sw_wdata,
  input  logic          bus_drv,
  input  logic          bus_phase,
  input  logic [DW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [5:0]    cfg_rd,
  output logic [DW-1:0] p0_out,
  output logic [DW-1:0] p0_oe,
  output logic [DW-1:0] p1_out,
  output logic [DW-1:0] p1_oe,
  output logic          bhe_en,
  output logic          wr_split,
  output logic [3:0]    cs_en
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] ALL_ON = {DW{1'b1}};
  localparam logic [DW-1:0] LOW_ON = {{(DW-HW){1'b0}}, {HW{1'b1}}};

  logic [1:0] bus_type, cs_cnt, bt_smp;
  logic       byte_dis, wr_cfg;

  assign bt_smp = int_start ? 2'b00 : strap_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_type <= bt_smp;
      byte_dis <= ~bt_smp[1];
      wr_cfg   <= ~strap_wr;
      cs_cnt   <= strap_cs;
    end else if (sw_we) begin
      bus_type <= sw_wdata[1:0];
      byte_dis <= sw_wdata[2];
      wr_cfg   <= sw_wdata[3];
    end
  end

  wire wide = bus_type[1];
  wire mux  = bus_type[0];
  wire [DW-1:0] data_oe = wide ? ALL_ON : LOW_ON;

  assign cfg_rd   = {cs_cnt, wr_cfg, byte_dis, bus_type};
  assign p0_out   = (mux && !bus_phase) ? bus_addr : bus_wdata;
  assign p1_out   = bus_addr;
  assign p1_oe    = (!mux && bus_drv) ? ALL_ON : '0;
  assign p0_oe    = !bus_drv ? '0 :
                    bus_phase ? data_oe :
                    mux ? ALL_ON : '0;
  assign bhe_en   = !byte_dis && !wr_cfg;
  assign wr_split = wr_cfg;

  always_comb begin
    case (cs_cnt)
      2'b00:   cs_en = 4'b1111;
      2'b01:   cs_en = 4'b0000;
      2'b10:   cs_en = 4'b0011;
      default: cs_en = 4'b0111;
    endcase
  end
endmodule

module bus_strap_cfg_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sw_we,
  input logic          bus_phase,
  input logic [5:0]    cfg_rd,
  input logic [DW-1:0] p0_oe,
  input logic [DW-1:0] p1_oe,
  input logic [3:0]    cs_en
);
  localparam int HW = DW / 2;

  assert_cs_locked_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfg_rd[5:4]));
  assert_cs_none_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd[5:4] == 2'b01) |-> (cs_en == 4'b0000));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> $stable(cfg_rd));
  assert_mux_p1_float_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_rd[0] |-> (p1_oe == '0));
  assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rd[1] && bus_phase) |-> (p0_oe[DW-1:HW] == '0));
endmodule

bind bus_strap_cfg bus_strap_cfg_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_bus_strap_cfg.sv
`timescale 1ns/1ps
module tb_bus_strap_cfg;
  logic clk = 0, rst = 1;
  logic [1:0] strap_bus = 2'b11, strap_cs = 2'b00;
  logic strap_wr = 1, int_start = 0, sw_we = 0, bus_drv = 0, bus_phase = 0;
  logic [5:0] sw_wdata = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic [5:0] cfg_rd;
  logic [15:0] p0_out, p0_oe, p1_out, p1_oe;
  logic bhe_en, wr_split;
  logic [3:0] cs_en;
  int checks = 0, fails = 0;

  bus_strap_cfg dut (.*);

  always #4 clk = ~clk;

  logic [1:0] m_bt = 0, m_cs = 0;
  logic m_bd = 0, m_wc = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_bt = int_start ? 2'd0 : strap_bus;
      m_bd = (m_bt < 2);
      m_wc = (strap_wr == 0);
      m_cs = strap_cs;
    end else if (sw_we) begin
      m_bt = sw_wdata[1:0];
      m_bd = sw_wdata[2];
      m_wc = sw_wdata[3];
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [15:0] e_p0, e_p0oe, e_p1oe, doe;
    logic [3:0] e_cs;
    doe = m_bt[1] ? 16'hFFFF : 16'h00FF;
    if (m_bt[0]) begin
      e_p0 = bus_phase ? bus_wdata : bus_addr;
      e_p1oe = 0;
      e_p0oe = !bus_drv ? 16'h0 : (bus_phase ? doe : 16'hFFFF);
    end else begin
      e_p0 = bus_wdata;
      e_p1oe = bus_drv ? 16'hFFFF : 16'h0;
      e_p0oe = (bus_drv && bus_phase) ? doe : 16'h0;
    end
    case (m_cs)
      0: e_cs = 4'hF;
      1: e_cs = 4'h0;
      2: e_cs = 4'h3;
      default: e_cs = 4'h7;
    endcase
    chk("R1 R2 R3 R4 R5 R8 R9 cfg_rd", cfg_rd, {m_cs, m_wc, m_bd, m_bt});
    chk("R6 R7 p0_out", p0_out, e_p0);
    chk("R6 R7 p0_oe", p0_oe, e_p0oe);
    chk("R7 p1_out", p1_out, bus_addr);
    chk("R6 R7 p1_oe", p1_oe, e_p1oe);
    chk("R8 bhe_en", bhe_en, (!m_bd && !m_wc));
    chk("R3 wr_split", wr_split, m_wc);
    chk("R4 cs_en", cs_en, e_cs);
  endtask

  task automatic do_reset(int n, bit force_int);
    rst = 1;
    for (int i = 0; i < n; i++) begin
      strap_bus = 2'($urandom); strap_wr = 1'($urandom);
      strap_cs = 2'($urandom); int_start = force_int | ($urandom % 4 == 0);
      @(negedge clk);
    end
    rst = 0;
    @(negedge clk);
  endtask

  task automatic traffic(int n);
    for (int i = 0; i < n; i++) begin
      compare_all();
      sw_we = ($urandom % 16 == 0);
      sw_wdata = 6'($urandom);
      bus_drv = 1'($urandom); bus_phase = 1'($urandom);
      bus_addr = 16'($urandom); bus_wdata = 16'($urandom);
      strap_bus = 2'($urandom); strap_cs = 2'($urandom);
      strap_wr = 1'($urandom); int_start = 1'($urandom);
      @(negedge clk);
    end
    sw_we = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 default straps: 16-bit mux, standard write, four chip selects
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 default cfg", cfg_rd, 6'b00_0_0_11);
    chk("R4 default cs", cs_en, 4'hF);
    chk("R8 default bhe", bhe_en, 1'b1);
    compare_all();
    // R2 internal start overrides straps at the final sample
    rst = 1; strap_bus = 2'b11; int_start = 0;
    @(negedge clk);
    int_start = 1;
    @(negedge clk);
    rst = 0; int_start = 0;
    @(negedge clk);
    chk("R2 int_start bus type", cfg_rd[1:0], 2'b00);
    chk("R8 int_start byte-dis", cfg_rd[2], 1'b1);
    // R4 software write to cs field ignored
    sw_wdata = 6'b01_0_0_01; sw_we = 1;
    @(negedge clk);
    sw_we = 0;
    chk("R4 cs locked", cfg_rd[5:4], m_cs);
    chk("R5 bus type written", cfg_rd[1:0], 2'b01);
    // R9 hold
    repeat (5) @(negedge clk);
    chk("R9 hold", cfg_rd[1:0], 2'b01);
    for (int e = 0; e < 24; e++) begin
      do_reset(2 + e % 3, (e % 5 == 0));
      traffic(150);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule